// File: doc/BRIEF.md
# Single to Half Precision Narrowing Converter

This block converts a 32-bit binary floating-point word to the 16-bit binary format: 5 exponent bits with bias 15 and 10 fraction bits. It accepts one operand per cycle under a valid strobe. The result and four exception flags appear exactly one clock later. The caller picks one of four rounding directions. A mode bit selects between the standard half format and an alternative half format. The alternative format treats the all-ones exponent as ordinary finite numbers, which gives one more binade of range. A third control chooses whether tininess is judged before or after rounding.

Rounding works by adding an increment under a discard mask, then truncating. The mask is 13 bits wide while the result stays in the normal half range. It widens one bit for every binade the value sits below the smallest normal half. The widening stops once every significand bit is below the kept quantum. If rounding carries out of the significand, the result moves up one binade. This can lift a large subnormal into the smallest normal, or push a large value into overflow. Special inputs are handled separately:

- A NaN is quietened.
- An infinity keeps its sign.
- A zero or subnormal single input flushes to a half zero with the same sign.

Top module: `hcv_narrow`

## Requirements
- R1: While rst_n is low, out_valid, out_half and every flag read 0. After each clock edge, out_valid equals in_valid from the cycle before. Result and flags load only on a cycle with in_valid high, and otherwise hold their last values.
- R2: An input with exponent field 8'hFF and a nonzero fraction gives {sign, 5'h1F, 1, fraction bits 21..13}. flag_inv is 1 exactly when input fraction bit 22 was 0. The other three flags are 0.
- R3: An input with exponent field 8'hFF and a zero fraction gives a signed infinity (exponent 5'h1F, fraction 0) in either format, with no flag raised.
- R4: An input with exponent field 0 gives {sign, 15'h0}. flag_inx is 1 exactly when the input fraction was nonzero. The other flags are 0.
- R5: A finite input whose value is exactly representable as a normal half converts with no flag raised. The half exponent field is the unbiased exponent plus 15.
- R6: rnd_mode 2'b00 rounds to nearest with ties to an even kept LSB. 2'b01 rounds toward +infinity, 2'b10 toward -infinity, and 2'b11 toward zero. flag_inx is 1 whenever any discarded bit was nonzero.
- R7: When rounding carries out of the kept significand, the result becomes the next power of two: fraction 0, exponent one higher. This includes the carry from the largest subnormal into the smallest normal.
- R8: With alt_half = 0, a rounded unbiased exponent above 15 gives {sign, 15'h7C00} with flag_ovf and flag_inx set, in every rounding mode.
- R9: With alt_half = 1, a rounded unbiased exponent of 16 encodes normally with exponent field 5'h1F. A rounded exponent above 16 gives {sign, 15'h7FFF} with flag_ovf and flag_inx set.
- R10: Inputs with unbiased exponent below -14 produce exponent field 0 and fraction equal to the value in units of 2^-24, rounded per R6. A result rounding to 0 gives a signed zero. Values far below 2^-24 still round up to the smallest subnormal when the direction requires it.
- R11: With tiny_early = 1, flag_unf is 1 for every finite input with unbiased exponent below -14, exact or not. With tiny_early = 0, flag_unf is 1 only when the result is inexact and below the smallest normal after rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_single | input | 32 | Single-precision operand |
| rnd_mode | input | 2 | Rounding direction: 00 nearest-even, 01 up, 10 down, 11 toward zero |
| alt_half | input | 1 | 1 selects the alternative half format with no infinity or NaN encoding |
| tiny_early | input | 1 | 1 judges tininess before rounding |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_half | output | 16 | Half-precision result |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow |
| flag_inx | output | 1 | Inexact |
| flag_inv | output | 1 | Invalid (signalling NaN input) |

## Verification
The formats are fixed by the package, so the bench builds the block with its only configuration. It sweeps every input exponent field from 0 to 255 in every combination of rounding direction, half format and tininess mode, under both signs. Each exponent is paired with fixed edge fractions, two fractions computed to sit exactly on a halfway point with even and odd kept LSBs, and a pseudo-random fraction. Because the sweep covers every exponent, it reaches each mask width from 13 bits up to the clamped maximum, every subnormal-to-normal carry, both overflow thresholds, and the deep underflow range where only the rounding direction decides between zero and the smallest subnormal.

// File: rtl/hcv_pkg.sv
package hcv_pkg;
  // Source format
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
  // Destination format
  localparam int HP_W      = 16;
  localparam int HP_EXP_W  = 5;
  localparam int HP_FRAC_W = 10;
  localparam int HP_BIAS   = (1 << (HP_EXP_W - 1)) - 1;
  // Derived datapath widths
  localparam int SIG_W     = SP_FRAC_W + 1;          // significand with hidden bit
  localparam int ACC_W     = SIG_W + 2;              // room for increment and carry
  localparam int DROP_W    = SP_FRAC_W - HP_FRAC_W;  // bits dropped in normal range
  localparam int MAX_DROP  = SIG_W + 1;              // every significand bit below half a quantum
  localparam int DC_W      = $clog2(MAX_DROP + 1);
  localparam int EXP_W     = SP_EXP_W + 2;           // signed unbiased exponent
  localparam int KEEP_W    = HP_FRAC_W + 2;          // kept significand incl. carry

  localparam logic signed [EXP_W-1:0] E_MIN_NORM = EXP_W'(1 - HP_BIAS);
  localparam logic signed [EXP_W-1:0] E_MAX_STD  = EXP_W'(HP_BIAS);
  localparam logic signed [EXP_W-1:0] E_MAX_ALT  = EXP_W'(HP_BIAS + 1);

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  // Number of low significand bits discarded for a given unbiased exponent.
  function automatic logic [DC_W-1:0] drop_count(input logic signed [EXP_W-1:0] e);
    int dc;
    if (e >= E_MIN_NORM) dc = DROP_W;
    else                 dc = DROP_W + int'(E_MIN_NORM) - int'(e);
    if (dc > MAX_DROP) dc = MAX_DROP;
    return DC_W'(dc);
  endfunction

  // Value added below the kept LSB before truncation.
  function automatic logic [ACC_W-1:0] round_incr(input logic [ACC_W-1:0] sig,
                                                  input logic [DC_W-1:0] dc,
                                                  input rmode_e rm,
                                                  input logic neg);
    logic [ACC_W-1:0] mask, half, rem, inc;
    mask = (ACC_W'(1) << dc) - ACC_W'(1);
    half = ACC_W'(1) << (dc - DC_W'(1));
    rem  = sig & mask;
    case (rm)
      RM_NEAR: inc = (rem == half) ? (sig & (half << 1)) : half;
      RM_UP:   inc = neg ? '0 : mask;
      RM_DOWN: inc = neg ? mask : '0;
      default: inc = '0;
    endcase
    return inc;
  endfunction
endpackage

// File: rtl/hcv_classify.sv
module hcv_classify
  import hcv_pkg::*;
(
  input  logic [SP_W-1:0]         word,
  output logic                    sign,
  output logic                    is_nan,
  output logic                    is_inf,
  output logic                    is_flush,
  output logic                    flush_nz,
  output logic                    quiet_in,
  output logic signed [EXP_W-1:0] unb_exp,
  output logic [SIG_W-1:0]        sig
);
  logic [SP_EXP_W-1:0]  exp_f;
  logic [SP_FRAC_W-1:0] frac_f;
  logic                 exp_ones, exp_zero, frac_nz;

  always_comb begin
    exp_f    = word[SP_W-2 -: SP_EXP_W];
    frac_f   = word[SP_FRAC_W-1:0];
    exp_ones = &exp_f;
    exp_zero = ~|exp_f;
    frac_nz  = |frac_f;
    sign     = word[SP_W-1];
    is_nan   = exp_ones & frac_nz;
    is_inf   = exp_ones & ~frac_nz;
    is_flush = exp_zero;
    flush_nz = exp_zero & frac_nz;
    quiet_in = frac_f[SP_FRAC_W-1];
    unb_exp  = EXP_W'(exp_f) - EXP_W'(SP_BIAS);
    sig      = {1'b1, frac_f};
  end
endmodule

// File: rtl/hcv_round.sv
module hcv_round
  import hcv_pkg::*;
(
  input  logic [SIG_W-1:0]        sig,
  input  logic signed [EXP_W-1:0] e_pre,
  input  logic                    neg,
  input  rmode_e                  rm,
  output logic [KEEP_W-1:0]       kept,
  output logic                    carry,
  output logic                    inexact,
  output logic                    sub_pre,
  output logic                    post_tiny,
  output logic signed [EXP_W-1:0] e_post
);
  logic [DC_W-1:0]  dc;
  logic [ACC_W-1:0] sig_x, mask, inc, sum;

  always_comb begin
    dc      = drop_count(e_pre);
    sig_x   = ACC_W'(sig);
    mask    = (ACC_W'(1) << dc) - ACC_W'(1);
    inc     = round_incr(sig_x, dc, rm, neg);
    sum     = sig_x + inc;
    inexact = |(sig_x & mask);
    sub_pre = e_pre < E_MIN_NORM;
    // Renormalise only in the normal range; subnormal carries fold into the packer.
    carry   = ~sub_pre & sum[SIG_W];
    kept    = carry ? KEEP_W'(sum >> (dc + DC_W'(1))) : KEEP_W'(sum >> dc);
    e_post  = e_pre + $signed({{(EXP_W-1){1'b0}}, carry});
    post_tiny = sub_pre & (kept < KEEP_W'(1 << HP_FRAC_W));
  end
endmodule

// File: rtl/hcv_pack.sv
module hcv_pack
  import hcv_pkg::*;
(
  input  logic                    neg,
  input  logic signed [EXP_W-1:0] e_post,
  input  logic [KEEP_W-1:0]       kept,
  input  logic                    sub_pre,
  input  logic                    alt,
  output logic                    ovf,
  output logic [HP_W-1:0]         half
);
  logic signed [EXP_W-1:0] e_lim;
  logic [HP_W-1:0]         biased;

  always_comb begin
    e_lim  = alt ? E_MAX_ALT : E_MAX_STD;
    ovf    = ~sub_pre & (e_post > e_lim);
    biased = HP_W'(e_post - E_MIN_NORM);
    if (ovf) begin
      if (alt) half = {neg, {HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b1}}};
      else     half = {neg, {HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b0}}};
    end else if (sub_pre) begin
      // kept counts units of the smallest subnormal; 1024 lands on the smallest normal
      half = {neg, (HP_W-1)'(kept)};
    end else begin
      // hidden bit in kept adds one into the exponent field
      half = {neg, {(HP_W-1){1'b0}}} + (biased << HP_FRAC_W) + HP_W'(kept);
    end
  end
endmodule

// File: rtl/hcv_narrow.sv
module hcv_narrow
  import hcv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SP_W-1:0] in_single,
  input  logic [1:0]      rnd_mode,
  input  logic            alt_half,
  input  logic            tiny_early,
  output logic            out_valid,
  output logic [HP_W-1:0] out_half,
  output logic            flag_ovf,
  output logic            flag_unf,
  output logic            flag_inx,
  output logic            flag_inv
);
  logic                    c_sign, c_nan, c_inf, c_flush, c_flush_nz, c_quiet;
  logic signed [EXP_W-1:0] c_exp;
  logic [SIG_W-1:0]        c_sig;

  logic [KEEP_W-1:0]       r_kept;
  logic                    r_carry, r_inexact, r_sub_pre, r_post_tiny;
  logic signed [EXP_W-1:0] r_e_post;

  logic                    p_ovf;
  logic [HP_W-1:0]         p_half;

  // Named events for the checker
  logic w_is_nan, w_ovf, w_carry, w_finite;

  logic [HP_W-1:0] n_half;
  logic            n_ovf, n_unf, n_inx, n_inv;

  hcv_classify u_cls (
    .word     (in_single),
    .sign     (c_sign),
    .is_nan   (c_nan),
    .is_inf   (c_inf),
    .is_flush (c_flush),
    .flush_nz (c_flush_nz),
    .quiet_in (c_quiet),
    .unb_exp  (c_exp),
    .sig      (c_sig)
  );

  hcv_round u_rnd (
    .sig       (c_sig),
    .e_pre     (c_exp),
    .neg       (c_sign),
    .rm        (rmode_e'(rnd_mode)),
    .kept      (r_kept),
    .carry     (r_carry),
    .inexact   (r_inexact),
    .sub_pre   (r_sub_pre),
    .post_tiny (r_post_tiny),
    .e_post    (r_e_post)
  );

  hcv_pack u_pck (
    .neg     (c_sign),
    .e_post  (r_e_post),
    .kept    (r_kept),
    .sub_pre (r_sub_pre),
    .alt     (alt_half),
    .ovf     (p_ovf),
    .half    (p_half)
  );

  always_comb begin
    w_finite = ~c_nan & ~c_inf & ~c_flush;
    w_is_nan = c_nan;
    w_ovf    = w_finite & p_ovf;
    w_carry  = w_finite & r_carry;
    n_ovf = 1'b0;
    n_unf = 1'b0;
    n_inx = 1'b0;
    n_inv = 1'b0;
    if (c_nan) begin
      n_half = {c_sign, {HP_EXP_W{1'b1}}, 1'b1, c_sig[SP_FRAC_W-2 -: HP_FRAC_W-1]};
      n_inv  = ~c_quiet;
    end else if (c_inf) begin
      n_half = {c_sign, {HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b0}}};
    end else if (c_flush) begin
      n_half = {c_sign, {(HP_W-1){1'b0}}};
      n_inx  = c_flush_nz;
    end else begin
      n_half = p_half;
      n_ovf  = p_ovf;
      n_inx  = r_inexact | p_ovf;
      n_unf  = tiny_early ? r_sub_pre : (r_post_tiny & r_inexact);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_half  <= '0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
      flag_inx  <= 1'b0;
      flag_inv  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_half <= n_half;
        flag_ovf <= n_ovf;
        flag_unf <= n_unf;
        flag_inx <= n_inx;
        flag_inv <= n_inv;
      end
    end
  end
endmodule

// File: rtl/hcv_narrow_chk.sv
module hcv_narrow_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_single,
  input logic        alt_half,
  input logic        out_valid,
  input logic [15:0] out_half,
  input logic        flag_ovf,
  input logic        flag_unf,
  input logic        flag_inx,
  input logic        flag_inv,
  input logic        w_is_nan,
  input logic        w_ovf,
  input logic        w_carry
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_half) && $stable(flag_ovf) && $stable(flag_unf)
                   && $stable(flag_inx) && $stable(flag_inv)));

  p_nan_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && w_is_nan |=> (out_half[14:9] == 6'h3F) && !flag_ovf && !flag_unf && !flag_inx);

  p_inv_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_inv |-> (out_half[14:9] == 6'h3F));

  p_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_single[30:0] == 31'h7F80_0000)
    |=> (out_half == {$past(in_single[31]), 15'h7C00}) && !flag_ovf && !flag_inx);

  p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_single[30:23] == 8'h00)
    |=> (out_half == {$past(in_single[31]), 15'h0000})
        && (flag_inx == ($past(in_single[22:0]) != 23'h0)));

  p_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && w_carry && !w_ovf |=> (out_half[9:0] == 10'h000));

  p_ovf_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && w_ovf && !alt_half |=> (out_half[14:0] == 15'h7C00) && flag_ovf && flag_inx);

  p_alt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && w_ovf && alt_half |=> (out_half[14:0] == 15'h7FFF) && flag_ovf && flag_inx);
endmodule

bind hcv_narrow hcv_narrow_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_single (in_single),
  .alt_half  (alt_half),
  .out_valid (out_valid),
  .out_half  (out_half),
  .flag_ovf  (flag_ovf),
  .flag_unf  (flag_unf),
  .flag_inx  (flag_inx),
  .flag_inv  (flag_inv),
  .w_is_nan  (w_is_nan),
  .w_ovf     (w_ovf),
  .w_carry   (w_carry)
);

// File: tb/sim_hcv_narrow.sv
`timescale 1ns/1ps
module sim_hcv_narrow;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_single = '0;
  logic [1:0]  rnd_mode = '0;
  logic        alt_half = 1'b0;
  logic        tiny_early = 1'b0;
  logic        out_valid;
  logic [15:0] out_half;
  logic        flag_ovf, flag_unf, flag_inx, flag_inv;

  int tests = 0;
  int fails = 0;
  int unsigned lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  hcv_narrow u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_single(in_single),
    .rnd_mode(rnd_mode), .alt_half(alt_half), .tiny_early(tiny_early),
    .out_valid(out_valid), .out_half(out_half), .flag_ovf(flag_ovf),
    .flag_unf(flag_unf), .flag_inx(flag_inx), .flag_inv(flag_inv)
  );

  // Reference: integer count of output quanta, rounded by comparison.
  function automatic void ref_conv(input logic [31:0] x, input int rm, input bit alt,
                                   input bit te, output logic [15:0] r,
                                   output logic [3:0] fl, output string tag);
    bit s; int ex, e, sh; longint sig, q, rem, hlf; bit up, inex, ovf, unf;
    s = x[31]; ex = int'(x[30:23]);
    fl = 4'b0000;  // {ovf, unf, inx, inv}
    if (ex == 255) begin
      if (x[22:0] != 0) begin
        r = {s, 5'h1F, 1'b1, x[21:13]}; fl[0] = ~x[22]; tag = "R2";
      end else begin
        r = {s, 15'h7C00}; tag = "R3";
      end
      return;
    end
    if (ex == 0) begin
      r = {s, 15'h0}; fl[1] = (x[22:0] != 0); tag = "R4";
      return;
    end
    e = ex - 127;
    sig = 64'h80_0000 + longint'(x[22:0]);
    sh = (e >= -14) ? 13 : (-1 - e);
    if (sh > 40) sh = 40;
    q = sig >> sh;
    rem = sig - (q << sh);
    hlf = 64'd1 << (sh - 1);
    case (rm)
      0: up = (rem > hlf) || (rem == hlf && q[0]);
      1: up = (rem != 0) && !s;
      2: up = (rem != 0) && s;
      default: up = 1'b0;
    endcase
    q = q + (up ? 1 : 0);
    inex = (rem != 0);
    ovf = 1'b0;
    tag = inex ? "R6" : "R5";
    if (e >= -14) begin
      if (q == 2048) begin q = 1024; e = e + 1; tag = "R7"; end
      ovf = e > (alt ? 16 : 15);
      if (ovf) begin
        r = alt ? {s, 15'h7FFF} : {s, 15'h7C00};
        tag = alt ? "R9" : "R8";
      end else begin
        r = {s, 5'(e + 15), 10'(q - 1024)};
        if (alt && e == 16) tag = "R9";
      end
      unf = 1'b0;
    end else begin
      if (q >= 1024) begin r = {s, 5'd1, 10'd0}; tag = "R7"; end
      else           begin r = {s, 5'd0, 10'(q)}; tag = "R10"; end
      unf = te ? 1'b1 : ((q < 1024) && inex);
      if (te && !inex) tag = "R11";
    end
    fl[3] = ovf; fl[2] = unf; fl[1] = inex || ovf;
  endfunction

  task automatic expect_out(input logic ev, input logic [15:0] eh, input logic [3:0] ef,
                            input string tag, input logic [31:0] x);
    logic [3:0] af;
    af = {flag_ovf, flag_unf, flag_inx, flag_inv};
    tests++;
    if (out_valid !== ev || out_half !== eh || af !== ef) begin
      fails++;
      $display("FAIL %s in=%h mode=%0d alt=%0d te=%0d: got v=%0b h=%h f=%b, expected v=%0b h=%h f=%b",
               tag, x, rnd_mode, alt_half, tiny_early, out_valid, out_half, af, ev, eh, ef);
    end
  endtask

  function automatic logic [22:0] frac_pat(input int p, input int ex, input int unsigned rnd);
    int e, sh;
    e = ex - 127;
    sh = (e >= -14) ? 13 : (-1 - e);
    if (sh > 23) sh = 23;
    case (p)
      0: return 23'h0;
      1: return 23'h1;
      2: return 23'h7FFFFF;
      3: return 23'h400000;
      4: return 23'h001000;
      5: return 23'h003000;
      6: return 23'h000FFF;
      7: return 23'h2AAAAA;
      8: return 23'h555555;
      9: return 23'h7FE000;
      10: return 23'h7FF000;
      11: return 23'(64'd1 << (sh - 1));                   // tie, even kept LSB
      12: return 23'((64'd1 << (sh - 1)) | (64'd1 << sh)); // tie, odd kept LSB
      default: return rnd[22:0];
    endcase
  endfunction

  initial begin
    repeat (160000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] ph; logic [3:0] pf; string pt; logic [31:0] px;
    bit pend;
    pend = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_out(1'b0, 16'h0000, 4'b0000, "R1", in_single);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: one-cycle latency, then hold while idle
    in_valid = 1'b1; in_single = 32'h3F80_0000;
    @(negedge clk);
    expect_out(1'b1, 16'h3C00, 4'b0000, "R1", 32'h3F80_0000);
    in_valid = 1'b0; in_single = 32'h4000_0001;
    @(negedge clk);
    expect_out(1'b0, 16'h3C00, 4'b0000, "R1", 32'h4000_0001);
    @(negedge clk);
    expect_out(1'b0, 16'h3C00, 4'b0000, "R1", 32'h4000_0001);

    // Sweep: every exponent field, all controls, both signs; pipelined one per cycle
    for (int rm = 0; rm < 4; rm++)
      for (int al = 0; al < 2; al++)
        for (int te = 0; te < 2; te++)
          for (int ex = 0; ex < 256; ex++)
            for (int p = 0; p < 14; p++)
              for (int sg = 0; sg < 2; sg++) begin
                logic [31:0] x;
                @(negedge clk);
                if (pend) expect_out(1'b1, ph, pf, pt, px);
                lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
                x = {1'(sg), 8'(ex), frac_pat(p, ex, lfsr)};
                in_valid = 1'b1; in_single = x; rnd_mode = 2'(rm);
                alt_half = 1'(al); tiny_early = 1'(te);
                ref_conv(x, rm, 1'(al), 1'(te), ph, pf, pt);
                px = x; pend = 1'b1;
              end
    @(negedge clk);
    expect_out(1'b1, ph, pf, pt, px);
    in_valid = 1'b0;
    @(negedge clk);
    // R1: idle cycle after the sweep leaves last result in place
    expect_out(1'b0, ph, pf, "R1", px);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule